// File: doc/BRIEF.md
# SIMD Float Min/Max Unit

This block selects, lane by lane, the smaller or larger of two vectors of single-precision floating-point values. A vector holds four 32-bit lanes. The selection uses a strict ordered less-than test, so the operation is not commutative. When the test fails, the second operand is returned with its exact bit pattern. That happens on equal values, on equal zeros of either sign, and whenever a NaN is present. One use is a masked conditional update: forcing a first-operand lane to all ones leaves the second operand's lane untouched.

Two controls change the lane behaviour. A scalar control limits the work to lane 0 and copies the upper lanes of the first operand to the result. A NaN-tolerant control makes a NaN in either input lose to the other input, in the style of a C-library fmin/fmax. Operands enter through a valid/ready handshake, and the result leaves through a registered valid/ready output stage with one cycle of latency.

Top module: `vfmm_top`

## Requirements
- R1: With in_op = 0 (minimum), each active lane returns the first operand A when A < B under ordered comparison, and otherwise returns B.
- R2: With in_op = 1 (maximum), each active lane returns A when B < A, and otherwise returns B.
- R3: When in_nan_aware = 0 and either lane value is a NaN (exponent field bits 30:23 all ones, mantissa bits 22:0 nonzero), the lane returns B bit-exactly for both minimum and maximum.
- R4: +0 (0x00000000) and -0 (0x80000000) compare equal, so a minimum or maximum of two zeros returns B's exact bit pattern.
- R5: Infinities (0x7F800000, 0xFF800000) are ordinary ordered values: +Inf never wins a minimum and -Inf never wins a maximum against a finite value.
- R6: With in_scalar = 1, only lane 0 (bits 31:0) is computed. Lanes 1 to 3 (lane i at bits 32i+31:32i) are copied unchanged from A. With in_scalar = 0, all four lanes are computed.
- R7: With in_nan_aware = 1, a NaN A lane yields B. Otherwise a NaN B lane yields A. With no NaN present, the lane follows R1 and R2.
- R8: An A lane of 0xFFFFFFFF (all ones, a NaN) with in_nan_aware = 0 leaves the B lane unchanged in the result, giving a masked conditional update.
- R9: A transfer is accepted on a rising edge with in_valid = 1 and in_ready = 1. out_valid is high after that edge and out_data carries the result of that transfer.
- R10: While out_valid = 1 and out_ready = 0, in_ready is 0, and out_valid and out_data hold their values.
- R11: While rst is high, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid |
| in_ready | output | 1 | Unit can accept a transfer |
| in_op | input | 1 | 0 = minimum, 1 = maximum |
| in_scalar | input | 1 | 0 = all lanes, 1 = lane 0 only |
| in_nan_aware | input | 1 | 1 = a NaN input loses to the other input |
| in_a | input | 128 | First operand, four 32-bit lanes |
| in_b | input | 128 | Second operand, four 32-bit lanes |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Registered result vector |

## Verification
Each lane result is due on the first rising edge after the accepting edge. The bench drives a transfer on a falling edge and removes in_valid on the next falling edge, where it samples out_valid and out_data: exactly one register stage away from the stimulus. The backpressure checks hold out_ready low and sample over two further falling edges. They confirm that in_ready stays low and the held result does not move. Once out_ready rises, the waiting transfer is accepted on that same edge, and its result is checked one falling edge later.

// File: rtl/vfmm_pkg.sv
package vfmm_pkg;

    localparam int LANE_W = 32;
    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int MAG_W  = LANE_W - 1;

    typedef logic [LANE_W-1:0] lane_t;

    typedef enum logic {
        OP_MIN = 1'b0,
        OP_MAX = 1'b1
    } op_e;

    typedef struct packed {
        op_e  op;
        logic scalar;
        logic nan_aware;
    } ctrl_t;

    function automatic logic f_is_nan(lane_t x);
        return (x[LANE_W-2 -: EXP_W] == {EXP_W{1'b1}}) && (x[MAN_W-1:0] != '0);
    endfunction

    function automatic logic f_is_zero(lane_t x);
        return x[MAG_W-1:0] == '0;
    endfunction

    // Strict ordered less-than on sign-magnitude encodings.
    function automatic logic f_ordered_lt(lane_t x, lane_t y);
        logic             sx;
        logic             sy;
        logic [MAG_W-1:0] mx;
        logic [MAG_W-1:0] my;
        sx = x[LANE_W-1];
        sy = y[LANE_W-1];
        mx = x[MAG_W-1:0];
        my = y[MAG_W-1:0];
        if (f_is_nan(x) || f_is_nan(y)) return 1'b0;
        if (f_is_zero(x) && f_is_zero(y)) return 1'b0;
        if (sx != sy) return sx;
        if (!sx) return mx < my;
        return mx > my;
    endfunction

endpackage

// File: rtl/vfmm_lane.sv
module vfmm_lane
    import vfmm_pkg::*;
(
    input  ctrl_t ctrl,
    input  lane_t a,
    input  lane_t b,
    output lane_t r
);
    logic a_nan;
    logic b_nan;
    logic a_lt_b;
    logic b_lt_a;
    logic pick_a;

    always_comb begin
        a_nan  = f_is_nan(a);
        b_nan  = f_is_nan(b);
        a_lt_b = f_ordered_lt(a, b);
        b_lt_a = f_ordered_lt(b, a);
        pick_a = (ctrl.op == OP_MIN) ? a_lt_b : b_lt_a;
        if (ctrl.nan_aware) begin
            if (a_nan)      pick_a = 1'b0;
            else if (b_nan) pick_a = 1'b1;
        end
        r = pick_a ? a : b;
    end
endmodule

// File: rtl/vfmm_lane_array.sv
module vfmm_lane_array
    import vfmm_pkg::*;
#(
    parameter int LANES = 4
) (
    input  ctrl_t                    ctrl,
    input  logic [LANES*LANE_W-1:0]  vec_a,
    input  logic [LANES*LANE_W-1:0]  vec_b,
    output logic [LANES*LANE_W-1:0]  vec_r
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_t lane_r;
        lane_t lane_a;
        lane_t lane_b;
        assign lane_a = vec_a[i*LANE_W +: LANE_W];
        assign lane_b = vec_b[i*LANE_W +: LANE_W];

        vfmm_lane u_lane (
            .ctrl (ctrl),
            .a    (lane_a),
            .b    (lane_b),
            .r    (lane_r)
        );

        if (i == 0) begin : g_base
            assign vec_r[i*LANE_W +: LANE_W] = lane_r;
        end else begin : g_upper
            assign vec_r[i*LANE_W +: LANE_W] = ctrl.scalar ? lane_a : lane_r;
        end
    end
endmodule

// File: rtl/vfmm_out_stage.sv
module vfmm_out_stage #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic accept;

    assign in_ready = !out_valid || out_ready;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/vfmm_top.sv
module vfmm_top
    import vfmm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_op,
    input  logic             in_scalar,
    input  logic             in_nan_aware,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_data
);
    ctrl_t            ctrl;
    logic [VEC_W-1:0] result;

    always_comb begin
        ctrl.op        = op_e'(in_op);
        ctrl.scalar    = in_scalar;
        ctrl.nan_aware = in_nan_aware;
    end

    vfmm_lane_array #(.LANES(LANES)) u_lanes (
        .ctrl  (ctrl),
        .vec_a (in_a),
        .vec_b (in_b),
        .vec_r (result)
    );

    vfmm_out_stage #(.W(VEC_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (result),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: rtl/vfmm_checker.sv
module vfmm_checker
    import vfmm_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * LANE_W
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_op,
    input logic             in_scalar,
    input logic             in_nan_aware,
    input logic [VEC_W-1:0] in_a,
    input logic [VEC_W-1:0] in_b,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_data
);
    logic acc;
    assign acc = in_valid && in_ready;

    p_reset_idle_r11: assert property (@(posedge clk) rst |=> !out_valid);

    p_accept_valid_r9: assert property (@(posedge clk) disable iff (rst)
        acc |=> out_valid);

    p_stall_ready_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_scalar_upper_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && in_scalar) |=> (out_data[VEC_W-1:LANE_W] == $past(in_a[VEC_W-1:LANE_W])));

    p_unordered_b_r3: assert property (@(posedge clk) disable iff (rst)
        (acc && !in_nan_aware && f_is_nan(in_a[LANE_W-1:0]))
        |=> (out_data[LANE_W-1:0] == $past(in_b[LANE_W-1:0])));

    p_zero_pair_b_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && !in_nan_aware && f_is_zero(in_a[LANE_W-1:0]) && f_is_zero(in_b[LANE_W-1:0]))
        |=> (out_data[LANE_W-1:0] == $past(in_b[LANE_W-1:0])));

    p_neg_inf_max_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && in_op && !in_nan_aware && in_a[LANE_W-1:0] == 32'hFF80_0000
         && !f_is_nan(in_b[LANE_W-1:0]))
        |=> (out_data[LANE_W-1:0] == $past(in_b[LANE_W-1:0])));
endmodule

bind vfmm_top vfmm_checker #(.LANES(LANES)) u_vfmm_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_op        (in_op),
    .in_scalar    (in_scalar),
    .in_nan_aware (in_nan_aware),
    .in_a         (in_a),
    .in_b         (in_b),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data)
);

// File: tb/vfmm_top_test.sv
module vfmm_top_test;
    localparam int NL = 4;
    localparam int VW = NL * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          in_op = 1'b0;
    logic          in_scalar = 1'b0;
    logic          in_nan_aware = 1'b0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [VW-1:0] out_data;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    vfmm_top #(.LANES(NL)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_scalar(in_scalar), .in_nan_aware(in_nan_aware),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    // ---- reference model built from the requirement text ----
    function automatic logic m_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    function automatic logic [31:0] m_key(logic [31:0] x);
        if (x[30:0] == 31'd0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic m_lt(logic [31:0] x, logic [31:0] y);
        return !m_nan(x) && !m_nan(y) && (m_key(x) < m_key(y));
    endfunction

    function automatic logic [31:0] m_lane(logic op, logic na, logic [31:0] a, logic [31:0] b);
        if (na && m_nan(a)) return b;
        if (na && m_nan(b)) return a;
        if (!op) return m_lt(a, b) ? a : b;
        return m_lt(b, a) ? a : b;
    endfunction

    function automatic logic [VW-1:0] m_vec(logic op, logic sc, logic na,
                                            logic [VW-1:0] a, logic [VW-1:0] b);
        logic [VW-1:0] r;
        for (int i = 0; i < NL; i++) begin
            if (sc && i != 0) r[i*32 +: 32] = a[i*32 +: 32];
            else              r[i*32 +: 32] = m_lane(op, na, a[i*32 +: 32], b[i*32 +: 32]);
        end
        return r;
    endfunction

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_vec(input logic [VW-1:0] act, input logic [VW-1:0] exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic op, input logic sc, input logic na,
                       input logic [VW-1:0] a, input logic [VW-1:0] b, input string tag);
        @(negedge clk);
        in_op = op; in_scalar = sc; in_nan_aware = na; in_a = a; in_b = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit(out_valid, 1'b1, "R9 out_valid after accept");
        chk_vec(out_data, m_vec(op, sc, na, a, b), tag);
    endtask

    function automatic logic [31:0] pick_lane();
        case ($urandom % 9)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'h7F80_0000;
            3: return 32'hFF80_0000;
            4: return 32'h7FC0_0000 | ($urandom & 32'h0000_FFFF);
            5: return 32'hFFFF_FFFF;
            6: return ($urandom % 2) ? 32'h3F80_0000 : 32'hBF80_0000;
            default: return $urandom;
        endcase
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [VW-1:0] va;
        logic [VW-1:0] vb;
        logic [VW-1:0] held;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        chk_bit(out_valid, 1'b0, "R11 out_valid in reset");
        chk_bit(in_ready, 1'b1, "R11 in_ready in reset");
        rst = 1'b0;

        // R1: 1 vs 2, 2 vs 1, -1 vs -2, -0.5 vs 0.5
        run(1'b0, 1'b0, 1'b0, {32'h3F80_0000, 32'h4000_0000, 32'hBF80_0000, 32'hBF00_0000},
                              {32'h4000_0000, 32'h3F80_0000, 32'hC000_0000, 32'h3F00_0000}, "R1 min");
        // R2
        run(1'b1, 1'b0, 1'b0, {32'h3F80_0000, 32'h4000_0000, 32'hBF80_0000, 32'h4040_0000},
                              {32'h4000_0000, 32'h3F80_0000, 32'hC000_0000, 32'h4040_0000}, "R2 max");
        // R3: NaN in either position, both ops
        run(1'b0, 1'b0, 1'b0, {32'h7FC0_0000, 32'h3F80_0000, 32'hFFC0_0001, 32'h7F80_0001},
                              {32'h3F80_0000, 32'h7FC0_0000, 32'h4000_0000, 32'hFF80_0000}, "R3 min unordered");
        run(1'b1, 1'b0, 1'b0, {32'h7FC0_0000, 32'h3F80_0000, 32'hFFC0_0001, 32'h7F80_0001},
                              {32'h3F80_0000, 32'h7FC0_0000, 32'h4000_0000, 32'hFF80_0000}, "R3 max unordered");
        // R4: signed zeros
        run(1'b0, 1'b0, 1'b0, {32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
                              {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000}, "R4 min zeros");
        run(1'b1, 1'b0, 1'b0, {32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 32'h8000_0000},
                              {32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000}, "R4 max zeros");
        // R5: infinities
        run(1'b0, 1'b0, 1'b0, {32'h7F80_0000, 32'hFF80_0000, 32'h40A0_0000, 32'h7F80_0000},
                              {32'h40A0_0000, 32'hC040_0000, 32'h7F80_0000, 32'hFF80_0000}, "R5 min inf");
        run(1'b1, 1'b0, 1'b0, {32'hFF80_0000, 32'h7F80_0000, 32'hC040_0000, 32'h7F7F_FFFF},
                              {32'hC040_0000, 32'h40A0_0000, 32'hFF80_0000, 32'h7F80_0000}, "R5 max inf");
        // R6: scalar, upper lanes from A
        run(1'b0, 1'b1, 1'b0, {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4000_0000},
                              {32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'h3F80_0000}, "R6 scalar min");
        run(1'b1, 1'b1, 1'b1, {32'h7FC0_0000, 32'h0000_0001, 32'h8000_0000, 32'h7FC0_0000},
                              {32'h0, 32'h0, 32'h0, 32'h3F80_0000}, "R6 scalar nan-aware");
        // R7: NaN-aware
        run(1'b0, 1'b0, 1'b1, {32'h7FC0_0000, 32'h3F80_0000, 32'h3F80_0000, 32'hFFFF_FFFF},
                              {32'h4000_0000, 32'h7FC0_0000, 32'h4000_0000, 32'hFFC0_0000}, "R7 nan-aware min");
        run(1'b1, 1'b0, 1'b1, {32'h7FC0_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h8000_0000},
                              {32'h4000_0000, 32'h7FC0_0000, 32'h4000_0000, 32'h0000_0000}, "R7 nan-aware max");
        // R8: masked update with all-ones lanes in A
        run(1'b0, 1'b0, 1'b0, {32'hFFFF_FFFF, 32'h3F80_0000, 32'hFFFF_FFFF, 32'h3F80_0000},
                              {32'h4000_0000, 32'h4000_0000, 32'hC000_0000, 32'hC000_0000}, "R8 masked update");

        // R9: output drains when idle
        @(negedge clk);
        chk_bit(out_valid, 1'b0, "R9 out_valid clears when idle");

        // R10: backpressure
        out_ready = 1'b0;
        va = {32'h3F80_0000, 32'h0, 32'h0, 32'h4000_0000};
        vb = {32'h4000_0000, 32'h0, 32'h0, 32'h3F80_0000};
        run(1'b0, 1'b0, 1'b0, va, vb, "R10 first result");
        held = m_vec(1'b0, 1'b0, 1'b0, va, vb);
        in_op = 1'b1; in_a = vb; in_b = va; in_valid = 1'b1;
        #1;
        chk_bit(in_ready, 1'b0, "R10 in_ready low while stalled");
        @(negedge clk);
        chk_bit(out_valid, 1'b1, "R10 out_valid held");
        chk_vec(out_data, held, "R10 out_data held");
        chk_bit(in_ready, 1'b0, "R10 in_ready still low");
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk_bit(out_valid, 1'b1, "R9 queued transfer accepted");
        chk_vec(out_data, m_vec(1'b1, 1'b0, 1'b0, vb, va), "R10 queued result after release");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [VW-1:0] ra;
            logic [VW-1:0] rb;
            logic rop;
            logic rsc;
            logic rna;
            string tag;
            for (int l = 0; l < NL; l++) begin
                ra[l*32 +: 32] = pick_lane();
                rb[l*32 +: 32] = pick_lane();
            end
            rop = 1'($urandom);
            rsc = (($urandom % 4) == 0);
            rna = (($urandom % 3) == 0);
            if (rsc)      tag = "R6 random scalar";
            else if (rna) tag = "R7 random nan-aware";
            else if (rop) tag = "R2 random max";
            else          tag = "R1 random min";
            run(rop, rsc, rna, ra, rb, tag);
        end

        summary();
        $finish;
    end
endmodule